// File: doc/BRIEF.md
# Dual-Result Carry-Select Adder

This block adds two unsigned operands of equal width and presents two results in the same combinational pass: the plain total A+B and the incremented total A+B+1. Each result carries its own carry-out bit. A typical user is a rounding stage that decides late whether it needs the bumped value and then only has to select between two results that are already settled.

The operand width is split into sub-adder blocks. Every block produces two candidate results, one assuming its carry-in is 0 and one assuming it is 1. A select chain then walks from the lowest block upward, twice. One pass is seeded with a global carry-in of 0 and yields the plain total. The other pass is seeded with 1 and yields the incremented total. Both passes share the same block candidates.

The split is a compile-time choice. The whole mode uses one block that spans the full width, and it is the default. The nibble mode uses 4-bit blocks, and the lowest block is narrowed so that the widths add up. The block core is also a compile-time choice: a parallel-prefix network by default, or a ripple chain. Declaring the two operands with different widths stops elaboration with an error.

Top module: `cscomp_adder`

## Requirements
- R1: `{sum_co, sum_o}` equals the (WIDTH+1)-bit unsigned value of opnd_a + opnd_b for every operand pair.
- R2: `{inc_co, inc_o}` equals the (WIDTH+1)-bit unsigned value of opnd_a + opnd_b + 1 for every operand pair.
- R3: When opnd_a + opnd_b equals 2^WIDTH - 1, sum_o is all ones with sum_co = 0, while inc_o is all zeros with inc_co = 1.
- R4: When both operands are all ones, sum_o is all ones except bit 0, which is 0, and sum_co = 1. In the same case inc_o is all ones and inc_co = 1.
- R5: In nibble split mode (SPLIT = SPLIT_NIBBLE), blocks are 4 bits wide and the lowest block holds WIDTH - 4*(ceil(WIDTH/4)-1) bits. Carries that cross every block boundary, for both the plain and the incremented result, give the arithmetic values of R1 and R2.
- R6: In the default whole split mode (SPLIT = SPLIT_WHOLE), a single full-width block gives the values of R1 and R2, including all-zero operands (sum 0, incremented sum 1).
- R7: With the ripple core (CORE = CORE_RIPPLE), the outputs equal those of R1 and R2, exactly as with the default prefix core.
- R8: Whenever sum_co is 1, inc_co is also 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | A_WIDTH | First unsigned operand |
| opnd_b | input | B_WIDTH | Second unsigned operand; B_WIDTH must equal A_WIDTH |
| sum_o | output | A_WIDTH | Low bits of A+B |
| sum_co | output | 1 | Carry-out of A+B |
| inc_o | output | A_WIDTH | Low bits of A+B+1 |
| inc_co | output | 1 | Carry-out of A+B+1 |

## Verification
The plain and the incremented result are always produced together, and the case that separates them most sharply is an operand pair whose total is exactly all ones. In that case the plain result shows no carry while the incremented result wraps to zero and raises its carry. The bench provokes this with complementary bit patterns and with all-ones plus zero, on each split mode and core at once. It judges both carry bits and both sum fields against arithmetic widened by one bit. Operands chosen to ripple a carry across every nibble boundary check that the two select passes steer each block independently.

// File: rtl/cscomp_pkg.sv
package cscomp_pkg;
  typedef enum logic [0:0] {SPLIT_WHOLE, SPLIT_NIBBLE} split_e;
  typedef enum logic [0:0] {CORE_PREFIX, CORE_RIPPLE} core_e;

  localparam int NIB = 4;

  function automatic int blk_count(input int w, input split_e m);
    return (m == SPLIT_WHOLE) ? 1 : (w + NIB - 1) / NIB;
  endfunction

  // Lowest block absorbs the remainder so that the widths sum to w.
  function automatic int blk_width(input int w, input split_e m, input int i);
    if (m == SPLIT_WHOLE) return w;
    if (i == 0) return w - NIB * (blk_count(w, m) - 1);
    return NIB;
  endfunction

  function automatic int blk_lsb(input int w, input split_e m, input int i);
    if (i == 0) return 0;
    return blk_width(w, m, 0) + NIB * (i - 1);
  endfunction
endpackage

// File: rtl/cscomp_ripple.sv
module cscomp_ripple #(
  parameter int BW = 4
) (
  input  logic [BW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [BW-1:0] s_z,
  output logic [BW-1:0] s_o,
  output logic          c_z,
  output logic          c_o
);
  logic [BW:0] cz;
  logic [BW:0] co;

  assign cz[0] = 1'b0;
  assign co[0] = 1'b1;

  for (genvar i = 0; i < BW; i++) begin : g_bit
    assign s_z[i]   = a[i] ^ b[i] ^ cz[i];
    assign s_o[i]   = a[i] ^ b[i] ^ co[i];
    assign cz[i+1]  = (a[i] & b[i]) | ((a[i] ^ b[i]) & cz[i]);
    assign co[i+1]  = (a[i] & b[i]) | ((a[i] ^ b[i]) & co[i]);
  end

  assign c_z = cz[BW];
  assign c_o = co[BW];
endmodule

// File: rtl/cscomp_prefix.sv
module cscomp_prefix #(
  parameter int BW = 4
) (
  input  logic [BW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [BW-1:0] s_z,
  output logic [BW-1:0] s_o,
  output logic          c_z,
  output logic          c_o
);
  localparam int LV = (BW > 1) ? $clog2(BW) : 0;

  // gg/pp[l][i]: group generate/propagate of bits i down to i-2^l+1
  logic [LV:0][BW-1:0] gg;
  logic [LV:0][BW-1:0] pp;

  assign gg[0] = a & b;
  assign pp[0] = a ^ b;

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar i = 0; i < BW; i++) begin : g_col
      if (i >= (1 << l)) begin : g_merge
        assign gg[l+1][i] = gg[l][i] | (pp[l][i] & gg[l][i-(1<<l)]);
        assign pp[l+1][i] = pp[l][i] & pp[l][i-(1<<l)];
      end else begin : g_pass
        assign gg[l+1][i] = gg[l][i];
        assign pp[l+1][i] = pp[l][i];
      end
    end
  end

  // One prefix tree serves both carry-in assumptions:
  // carry into bit i+1 is G for cin=0 and G|P for cin=1.
  assign s_z[0] = pp[0][0];
  assign s_o[0] = ~pp[0][0];
  for (genvar i = 1; i < BW; i++) begin : g_sum
    assign s_z[i] = pp[0][i] ^ gg[LV][i-1];
    assign s_o[i] = pp[0][i] ^ (gg[LV][i-1] | pp[LV][i-1]);
  end

  assign c_z = gg[LV][BW-1];
  assign c_o = gg[LV][BW-1] | pp[LV][BW-1];
endmodule

// File: rtl/cscomp_block.sv
module cscomp_block
  import cscomp_pkg::*;
#(
  parameter int    BW   = 4,
  parameter core_e CORE = CORE_PREFIX
) (
  input  logic [BW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [BW-1:0] s_z,
  output logic [BW-1:0] s_o,
  output logic          c_z,
  output logic          c_o
);
  if (CORE == CORE_RIPPLE) begin : g_rip
    cscomp_ripple #(.BW(BW)) u_core (
      .a(a), .b(b), .s_z(s_z), .s_o(s_o), .c_z(c_z), .c_o(c_o)
    );
  end else begin : g_pfx
    cscomp_prefix #(.BW(BW)) u_core (
      .a(a), .b(b), .s_z(s_z), .s_o(s_o), .c_z(c_z), .c_o(c_o)
    );
  end
endmodule

// File: rtl/cscomp_adder.sv
module cscomp_adder
  import cscomp_pkg::*;
#(
  parameter int     A_WIDTH = 16,
  parameter int     B_WIDTH = A_WIDTH,
  parameter split_e SPLIT   = SPLIT_WHOLE,
  parameter core_e  CORE    = CORE_PREFIX
) (
  input  logic [A_WIDTH-1:0] opnd_a,
  input  logic [B_WIDTH-1:0] opnd_b,
  output logic [A_WIDTH-1:0] sum_o,
  output logic               sum_co,
  output logic [A_WIDTH-1:0] inc_o,
  output logic               inc_co
);
  localparam int W    = A_WIDTH;
  localparam int NBLK = blk_count(W, SPLIT);

  if (A_WIDTH != B_WIDTH) begin : g_width_mismatch
    $error("cscomp_adder: operand widths differ");
  end

  logic [W-1:0] b_w;
  assign b_w = W'(opnd_b);

  // select chains: k_z seeded with 0 (plain), k_o seeded with 1 (incremented)
  logic [NBLK:0] k_z;
  logic [NBLK:0] k_o;
  assign k_z[0] = 1'b0;
  assign k_o[0] = 1'b1;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    localparam int LSB = blk_lsb(W, SPLIT, g);
    localparam int BWD = blk_width(W, SPLIT, g);

    logic [BWD-1:0] bs_z, bs_o;
    logic           bc_z, bc_o;

    cscomp_block #(.BW(BWD), .CORE(CORE)) u_blk (
      .a  (opnd_a[LSB +: BWD]),
      .b  (b_w[LSB +: BWD]),
      .s_z(bs_z),
      .s_o(bs_o),
      .c_z(bc_z),
      .c_o(bc_o)
    );

    assign sum_o[LSB +: BWD] = k_z[g] ? bs_o : bs_z;
    assign inc_o[LSB +: BWD] = k_o[g] ? bs_o : bs_z;
    assign k_z[g+1]          = k_z[g] ? bc_o : bc_z;
    assign k_o[g+1]          = k_o[g] ? bc_o : bc_z;
  end

  assign sum_co = k_z[NBLK];
  assign inc_co = k_o[NBLK];
endmodule

// File: rtl/cscomp_adder_chk.sv
module cscomp_adder_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] sum_o,
  input logic         sum_co,
  input logic [W-1:0] inc_o,
  input logic         inc_co
);
  logic [W:0] ref_tot;
  assign ref_tot = {1'b0, opnd_a} + {1'b0, opnd_b};

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, sum_o, sum_co, inc_o, inc_co})) begin
      assert_plain_total_R1: assert ({sum_co, sum_o} == ref_tot)
        else $error("plain total mismatch");
      assert_inc_is_plain_plus_one_R2: assert ({inc_co, inc_o} == (W+1)'({sum_co, sum_o} + 1'b1))
        else $error("incremented total mismatch");
      if (ref_tot == {1'b0, {W{1'b1}}}) begin
        assert_wrap_only_inc_R3: assert (inc_co && (inc_o == '0) && !sum_co)
          else $error("all-ones wrap mishandled");
      end
      if (sum_co) begin
        assert_carry_implies_inc_carry_R8: assert (inc_co)
          else $error("plain carry without incremented carry");
      end
    end
  end
endmodule

bind cscomp_adder cscomp_adder_chk #(.W(A_WIDTH)) u_chk (
  .opnd_a(opnd_a),
  .opnd_b(opnd_b),
  .sum_o (sum_o),
  .sum_co(sum_co),
  .inc_o (inc_o),
  .inc_co(inc_co)
);

// File: tb/cscomp_adder_bench.sv
module cscomp_adder_bench;
  import cscomp_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] ta = '0;
  logic [15:0] tb = '0;

  // 16-bit whole-block prefix (defaults)
  logic [15:0] w_s, w_i;
  logic        w_sc, w_ic;
  cscomp_adder u_cscomp_adder (
    .opnd_a(ta), .opnd_b(tb), .sum_o(w_s), .sum_co(w_sc), .inc_o(w_i), .inc_co(w_ic)
  );

  // 14-bit nibble prefix: blocks 2,4,4,4
  logic [13:0] n_s, n_i;
  logic        n_sc, n_ic;
  cscomp_adder #(.A_WIDTH(14), .SPLIT(SPLIT_NIBBLE)) u_cscomp_adder_n (
    .opnd_a(ta[13:0]), .opnd_b(tb[13:0]), .sum_o(n_s), .sum_co(n_sc), .inc_o(n_i), .inc_co(n_ic)
  );

  // 10-bit nibble ripple: blocks 2,4,4
  logic [9:0] r_s, r_i;
  logic       r_sc, r_ic;
  cscomp_adder #(.A_WIDTH(10), .SPLIT(SPLIT_NIBBLE), .CORE(CORE_RIPPLE)) u_cscomp_adder_r (
    .opnd_a(ta[9:0]), .opnd_b(tb[9:0]), .sum_o(r_s), .sum_co(r_sc), .inc_o(r_i), .inc_co(r_ic)
  );

  function automatic logic [16:0] ref_val(input logic [15:0] a, input logic [15:0] b,
                                          input int w, input bit inc);
    logic [16:0] m;
    logic [16:0] x;
    m = (17'd1 << w) - 17'd1;
    x = ({1'b0, a} & m) + ({1'b0, b} & m) + {16'd0, inc};
    return x & ((m << 1) | 17'd1);
  endfunction

  task automatic cmp(input string tag, input string what, input logic [16:0] act,
                     input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (a=%h b=%h)", tag, what, act, exp, ta, tb);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b,
                       input string tw, input string tn, input string tr);
    @(negedge clk);
    ta = a;
    tb = b;
    #1;
    cmp(tw, "whole16 sum", {w_sc, w_s},        ref_val(a, b, 16, 1'b0));
    cmp(tw, "whole16 inc", {w_ic, w_i},        ref_val(a, b, 16, 1'b1));
    cmp(tn, "nib14 sum",   {2'b0, n_sc, n_s},  ref_val(a, b, 14, 1'b0));
    cmp(tn, "nib14 inc",   {2'b0, n_ic, n_i},  ref_val(a, b, 14, 1'b1));
    cmp(tr, "rip10 sum",   {6'b0, r_sc, r_s},  ref_val(a, b, 10, 1'b0));
    cmp(tr, "rip10 inc",   {6'b0, r_ic, r_i},  ref_val(a, b, 10, 1'b1));
  endtask

  task automatic t_zero;  // R6, R1, R2
    apply(16'h0000, 16'h0000, "R6", "R5", "R7");
    checks++;
    if (!(w_s == 16'h0000 && w_i == 16'h0001 && !w_sc && !w_ic)) begin
      fails++;
      $display("FAIL R6 zero operands: actual sum=%h inc=%h expected 0000/0001", w_s, w_i);
    end
  endtask

  task automatic t_wrap;  // R3
    apply(16'hFFFF, 16'h0000, "R3", "R3", "R3");
    checks++;
    if (!(w_s == 16'hFFFF && !w_sc && w_i == 16'h0000 && w_ic)) begin
      fails++;
      $display("FAIL R3 wrap: actual %b%h/%b%h expected 0ffff/10000", w_sc, w_s, w_ic, w_i);
    end
    apply(16'h5555, 16'hAAAA, "R3", "R3", "R3");
    apply(16'h00FF, 16'hFF00, "R3", "R3", "R3");
  endtask

  task automatic t_max;  // R4
    apply(16'hFFFF, 16'hFFFF, "R4", "R4", "R4");
    checks++;
    if (!(w_s == 16'hFFFE && w_sc && w_i == 16'hFFFF && w_ic)) begin
      fails++;
      $display("FAIL R4 all ones: actual %b%h/%b%h expected 1fffe/1ffff", w_sc, w_s, w_ic, w_i);
    end
  endtask

  task automatic t_alt;  // R1, R2
    apply(16'hAAAA, 16'hAAAA, "R1", "R1", "R1");
    apply(16'h5555, 16'h5555, "R2", "R2", "R2");
    apply(16'hAAAA, 16'h5554, "R2", "R2", "R2");
  endtask

  task automatic t_boundary;  // R5: carries across each nibble boundary
    apply(16'h0003, 16'h0001, "R6", "R5", "R5");
    apply(16'h0003, 16'h0000, "R6", "R5", "R5");
    apply(16'h003F, 16'h0000, "R6", "R5", "R5");
    apply(16'h03FF, 16'h0001, "R6", "R5", "R5");
    apply(16'h0FFE, 16'h0001, "R6", "R5", "R5");
    apply(16'h3FFF, 16'h0000, "R6", "R5", "R5");
    apply(16'h2000, 16'h2000, "R6", "R5", "R5");
  endtask

  task automatic t_random;  // R1, R2, R7
    for (int k = 0; k < 300; k++) begin
      apply(16'($urandom), 16'($urandom), "R1", "R2", "R7");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_zero();
    t_wrap();
    t_max();
    t_alt();
    t_boundary();
    t_random();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule